// File: doc/BRIEF.md
# NAND Flash Command Cycle Sequencer

This block drives a raw 8-bit NAND flash bus. Software sets up three command bytes, a 16-bit column field, a 32-bit row field, a byte count and a 15-bit code word, then pulses start. Each set bit in the code word turns on one bus phase. The sequencer runs the enabled phases in fixed NAND protocol order and skips the rest, so one small engine covers reset, status, ID, page read and page program without a separate state machine per command.

Bytes written to the flash are taken from an internal word buffer, and bytes read from it are stored there. Within each 32-bit word the bytes sit most-significant first. Software reaches the buffer through a word write port and a word read port. Strobe widths, setup and hold are counted in clock cycles and set by parameters. The ready/busy wait reads a line that the row field selects and has a programmable timeout.

Top module: `nand_cycle_seq`

## Requirements
- R1: While rst_ni is low and right after it, busy_o, done_o, timeout_err_o, nand_cle_o, nand_ale_o and nand_dq_oe_o are 0. nand_we_no, nand_re_no and every nand_ce_no bit are 1.
- R2: Code bit meanings: 14 first command, 13 and 12 column bytes, 11, 10 and 9 row bytes, 8 write data, 7 second command, 6 ready wait, 5 read data, 4 third command, 3 status read, 2 ID read. Bits 1:0 are ignored. The enabled phases run from the highest bit to the lowest, and a cleared bit issues no bus cycle.
- R3: Bit 13 sends col[7:0] and bit 12 sends col[15:8]. Bits 11, 10 and 9 send row[7:0], row[15:8] and row[23:16]. Each is one ALE cycle, and only the enabled bytes are sent.
- R4: Code 0x4040 issues one command cycle and then waits on ready. busy_o stays 1 for as long as the selected line is low.
- R5: The ready wait watches line row[31:28] of nand_rb_i and ignores all other lines. It also ignores the line for T_WB cycles after entry. It ends only after the line, passed through a two-stage synchroniser, has been seen high on two consecutive cycles. done_o therefore comes at least 3 cycles after the line rises.
- R6: If the wait lasts timeout_i cycles, timeout_err_o is set, every remaining phase is dropped and done_o pulses. timeout_err_o is cleared by the next accepted start.
- R7: Read-data bytes go into the buffer from byte 0 upward. Byte n sits in word n/4 at bits [31-8*(n%4) -: 8]. Read data, status and ID bytes share one pointer, in that order.
- R8: The write-data phase sends count_i bytes from the buffer, starting at byte 0 and using the same big-endian placement. When count_i is 0 the phase issues no cycle.
- R9: A WE# or RE# low pulse lasts T_LOW cycles and is followed by T_HIGH high cycles. CLE or ALE rises T_SETUP cycles before the WE# fall and is held T_HIGH+T_HOLD cycles after the rise. Read data is sampled on the last low cycle of RE#.
- R10: busy_o is 1 from the cycle after an accepted start until the last phase ends. done_o is then a one-cycle pulse while busy_o is 0. A start_i pulse while busy_o is 1 is ignored.
- R11: While busy_o is 1, nand_ce_no equals ~row[27:24] as latched at start. It is all ones while idle.
- R12: A status read takes one byte. An ID read takes ID_BYTES bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| code_i | input | 15 | Phase enable word |
| cmd1_i | input | 8 | First command byte |
| cmd2_i | input | 8 | Second command byte |
| cmd3_i | input | 8 | Third command byte |
| col_i | input | 16 | Column address field |
| row_i | input | 32 | Row address [23:0], chip enables [27:24], ready line select [31:28] |
| count_i | input | CNT_W | Byte count for the write and read data phases |
| timeout_i | input | TO_W | Ready wait limit in cycles |
| buf_we_i | input | 1 | Software word write strobe |
| buf_waddr_i | input | AW | Software write word index |
| buf_wdata_i | input | 32 | Software write word |
| buf_raddr_i | input | AW | Software read word index |
| buf_rdata_o | output | 32 | Software read word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_err_o | output | 1 | Last ready wait timed out |
| nand_ce_no | output | 4 | Chip enables, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus drive enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb_i | input | NUM_RB | Ready/busy lines, high = ready |

## Verification
The bench builds the block with a four-word buffer, T_SETUP=1, T_LOW=2, T_HIGH=1, T_HOLD=1, T_WB=2, ID_BYTES=2, four ready lines and an 8-bit timeout counter. These short strobe widths make each pulse-width count exact and cheap to check. With a 16-byte buffer, a read followed by an ID read overwrites only part of one word, which exposes the byte placement. A 20-cycle timeout lets the abort path run in a short test, and with four ready lines the bench can hold a line that is not selected low.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_WR = 2'd2, K_RD = 2'd3} bus_kind_e;

  localparam int CODE_W   = 15;
  localparam int PH_CMD1  = 14;
  localparam int PH_COL0  = 13;
  localparam int PH_COL1  = 12;
  localparam int PH_ROW0  = 11;
  localparam int PH_ROW1  = 10;
  localparam int PH_ROW2  = 9;
  localparam int PH_WDATA = 8;
  localparam int PH_CMD2  = 7;
  localparam int PH_WAIT  = 6;
  localparam int PH_RDATA = 5;
  localparam int PH_CMD3  = 4;
  localparam int PH_STAT  = 3;
  localparam int PH_ID    = 2;
  localparam logic [CODE_W-1:0] CODE_USED = 15'h7FFC;
endpackage

// File: rtl/nand_phase_pick.sv
module nand_phase_pick #(
  parameter int W  = 15,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = |mask_i;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (mask_i[i]) idx_o = i[IW-1:0];
    end
  end
endmodule

// File: rtl/nand_strobe.sv
module nand_strobe
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_HIGH  = 2,
  parameter int T_HOLD  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  bus_kind_e  kind_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] dq_i,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic [7:0] rbyte_o,
  output logic       done_o
);
  localparam int T_A   = (T_SETUP > T_LOW) ? T_SETUP : T_LOW;
  localparam int T_B   = (T_HIGH > T_HOLD) ? T_HIGH : T_HOLD;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CW    = $clog2(T_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD} st_e;

  st_e       st_q;
  logic [CW-1:0] cnt_q;
  bus_kind_e kind_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      kind_q  <= K_CMD;
      byte_q  <= '0;
      rbyte_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (go_i) begin
          kind_q <= kind_i;
          byte_q <= byte_i;
          st_q   <= S_SETUP;
          cnt_q  <= CW'(T_SETUP - 1);
        end
        S_SETUP: if (cnt_q == '0) begin
          st_q  <= S_LOW;
          cnt_q <= CW'(T_LOW - 1);
        end else cnt_q <= cnt_q - 1'b1;
        S_LOW: if (cnt_q == '0) begin
          if (kind_q == K_RD) rbyte_o <= dq_i;
          st_q  <= S_HIGH;
          cnt_q <= CW'(T_HIGH - 1);
        end else cnt_q <= cnt_q - 1'b1;
        S_HIGH: if (cnt_q == '0) begin
          st_q  <= S_HOLD;
          cnt_q <= CW'(T_HOLD - 1);
        end else cnt_q <= cnt_q - 1'b1;
        S_HOLD: if (cnt_q == '0) begin
          st_q   <= S_IDLE;
          done_o <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic active;
  assign active  = (st_q != S_IDLE);
  assign cle_o   = active && (kind_q == K_CMD);
  assign ale_o   = active && (kind_q == K_ADDR);
  assign we_no   = !((st_q == S_LOW) && (kind_q != K_RD));
  assign re_no   = !((st_q == S_LOW) && (kind_q == K_RD));
  assign dq_oe_o = active && (kind_q != K_RD);
  assign dq_o    = byte_q;

  a_r9_we_re_excl: assert property (@(posedge clk_i) disable iff (!rst_ni) we_no || re_no);
  a_r9_latch_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> ($stable(cle_o) && $stable(ale_o)));
  a_r9_go_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (st_q == S_IDLE));
endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait #(
  parameter int NUM_RB = 4,
  parameter int TO_W   = 20,
  parameter int T_WB   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_RB-1:0] rb_i,
  input  logic [3:0]        sel_i,
  input  logic [TO_W-1:0]   limit_i,
  output logic              done_o,
  output logic              timeout_o
);
  localparam int WB_W = $clog2(T_WB + 2);

  logic [NUM_RB-1:0] s1_q, s2_q;
  logic [15:0]       rb_pad;
  logic              sel_hi, active_q, hi_seen_q, ready_now;
  logic [TO_W-1:0]   tcnt_q;
  logic [WB_W-1:0]   wb_q;

  assign rb_pad    = 16'(s2_q);
  assign sel_hi    = rb_pad[sel_i];
  assign ready_now = active_q && (wb_q == '0) && sel_hi && hi_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0; s2_q <= '0;
      active_q <= 1'b0; hi_seen_q <= 1'b0;
      tcnt_q <= '0; wb_q <= '0;
      done_o <= 1'b0; timeout_o <= 1'b0;
    end else begin
      s1_q <= rb_i;
      s2_q <= s1_q;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (start_i) begin
        active_q  <= 1'b1;
        hi_seen_q <= 1'b0;
        tcnt_q    <= '0;
        wb_q      <= WB_W'(T_WB);
      end else if (active_q) begin
        if (ready_now) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end else if (tcnt_q == limit_i) begin
          active_q  <= 1'b0;
          done_o    <= 1'b1;
          timeout_o <= 1'b1;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
          if (wb_q != '0) begin
            wb_q      <= wb_q - 1'b1;
            hi_seen_q <= 1'b0;
          end else hi_seen_q <= sel_hi;
        end
      end
    end
  end

  a_r6_timeout_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  a_r5_two_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o) |-> ($past(sel_hi) && $past(sel_hi, 2)));
endmodule

// File: rtl/nand_word_buf.sv
module nand_word_buf #(
  parameter int WORDS = 16,
  localparam int AW    = $clog2(WORDS),
  localparam int BAW   = $clog2(WORDS * 4)
) (
  input  logic           clk_i,
  input  logic           sw_we_i,
  input  logic [AW-1:0]  sw_waddr_i,
  input  logic [31:0]    sw_wdata_i,
  input  logic [AW-1:0]  sw_raddr_i,
  output logic [31:0]    sw_rdata_o,
  input  logic           hw_we_i,
  input  logic [BAW-1:0] hw_waddr_i,
  input  logic [7:0]     hw_wbyte_i,
  input  logic [BAW-1:0] hw_raddr_i,
  output logic [7:0]     hw_rbyte_o
);
  // byte 4w+0 is bits 31:24 of word w
  logic [7:0] mem_q [WORDS*4];

  always_ff @(posedge clk_i) begin
    if (sw_we_i) begin
      for (int l = 0; l < 4; l++) mem_q[{sw_waddr_i, 2'(l)}] <= sw_wdata_i[31-8*l -: 8];
    end
    if (hw_we_i) mem_q[hw_waddr_i] <= hw_wbyte_i;
  end

  always_comb begin
    for (int l = 0; l < 4; l++) sw_rdata_o[31-8*l -: 8] = mem_q[{sw_raddr_i, 2'(l)}];
  end
  assign hw_rbyte_o = mem_q[hw_raddr_i];
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  parameter int T_SETUP   = 2,
  parameter int T_LOW     = 3,
  parameter int T_HIGH    = 2,
  parameter int T_HOLD    = 2,
  parameter int T_WB      = 4,
  parameter int ID_BYTES  = 5,
  parameter int NUM_RB    = 4,
  parameter int TO_W      = 20,
  localparam int AW       = $clog2(BUF_WORDS),
  localparam int BAW      = $clog2(BUF_WORDS * 4),
  localparam int CNT_W    = BAW + 1,
  localparam int CE_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [14:0]       code_i,
  input  logic [7:0]        cmd1_i,
  input  logic [7:0]        cmd2_i,
  input  logic [7:0]        cmd3_i,
  input  logic [15:0]       col_i,
  input  logic [31:0]       row_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic              buf_we_i,
  input  logic [AW-1:0]     buf_waddr_i,
  input  logic [31:0]       buf_wdata_i,
  input  logic [AW-1:0]     buf_raddr_i,
  output logic [31:0]       buf_rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_err_o,
  output logic [CE_W-1:0]   nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [7:0]        nand_dq_i,
  input  logic [NUM_RB-1:0] nand_rb_i
);
  localparam int IW = $clog2(CODE_W);

  typedef enum logic [1:0] {C_IDLE, C_PICK, C_BUS, C_WAIT} ctl_e;

  ctl_e              st_q;
  logic [CODE_W-1:0] pend_q;
  logic [7:0]        cmd1_q, cmd2_q, cmd3_q;
  logic [15:0]       col_q;
  logic [31:0]       row_q;
  logic [CNT_W-1:0]  count_q, pcnt_q, lim;
  logic [TO_W-1:0]   tmo_q;
  logic [BAW-1:0]    wptr_q, rptr_q;

  logic              pick_valid, multi, is_read, phase_full;
  logic [IW-1:0]     pick_idx;
  logic              go, rb_start, strb_done, rb_done, rb_to;
  bus_kind_e         go_kind;
  logic [7:0]        go_byte, strb_rbyte, hw_rbyte;

  nand_phase_pick #(.W(CODE_W)) u_pick (
    .mask_i(pend_q), .valid_o(pick_valid), .idx_o(pick_idx)
  );

  always_comb begin
    go_kind = K_CMD;
    go_byte = 8'h00;
    lim     = CNT_W'(1);
    multi   = 1'b0;
    is_read = 1'b0;
    unique case (int'(pick_idx))
      PH_CMD1:  go_byte = cmd1_q;
      PH_COL0:  begin go_kind = K_ADDR; go_byte = col_q[7:0];   end
      PH_COL1:  begin go_kind = K_ADDR; go_byte = col_q[15:8];  end
      PH_ROW0:  begin go_kind = K_ADDR; go_byte = row_q[7:0];   end
      PH_ROW1:  begin go_kind = K_ADDR; go_byte = row_q[15:8];  end
      PH_ROW2:  begin go_kind = K_ADDR; go_byte = row_q[23:16]; end
      PH_WDATA: begin go_kind = K_WR; go_byte = hw_rbyte; lim = count_q; multi = 1'b1; end
      PH_CMD2:  go_byte = cmd2_q;
      PH_RDATA: begin go_kind = K_RD; lim = count_q; multi = 1'b1; is_read = 1'b1; end
      PH_CMD3:  go_byte = cmd3_q;
      PH_STAT:  begin go_kind = K_RD; multi = 1'b1; is_read = 1'b1; end
      PH_ID:    begin go_kind = K_RD; lim = CNT_W'(ID_BYTES); multi = 1'b1; is_read = 1'b1; end
      default:  ;
    endcase
  end

  assign phase_full = multi && (pcnt_q == lim);
  assign go       = (st_q == C_PICK) && pick_valid && (int'(pick_idx) != PH_WAIT) && !phase_full;
  assign rb_start = (st_q == C_PICK) && pick_valid && (int'(pick_idx) == PH_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= C_IDLE; pend_q <= '0;
      cmd1_q <= '0; cmd2_q <= '0; cmd3_q <= '0;
      col_q <= '0; row_q <= '0; count_q <= '0; tmo_q <= '0;
      wptr_q <= '0; rptr_q <= '0; pcnt_q <= '0;
      timeout_err_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        C_IDLE: if (start_i) begin
          pend_q  <= code_i & CODE_USED;
          cmd1_q  <= cmd1_i; cmd2_q <= cmd2_i; cmd3_q <= cmd3_i;
          col_q   <= col_i;  row_q  <= row_i;
          count_q <= count_i; tmo_q <= timeout_i;
          wptr_q  <= '0; rptr_q <= '0; pcnt_q <= '0;
          timeout_err_o <= 1'b0;
          st_q    <= C_PICK;
        end
        C_PICK: begin
          if (!pick_valid) begin
            st_q   <= C_IDLE;
            done_o <= 1'b1;
          end else if (rb_start) begin
            st_q <= C_WAIT;
          end else if (phase_full) begin
            pend_q[pick_idx] <= 1'b0;
            pcnt_q <= '0;
          end else begin
            st_q <= C_BUS;
          end
        end
        C_BUS: if (strb_done) begin
          if (is_read) rptr_q <= rptr_q + 1'b1;
          if (go_kind == K_WR) wptr_q <= wptr_q + 1'b1;
          if (multi) pcnt_q <= pcnt_q + 1'b1;
          else pend_q[pick_idx] <= 1'b0;
          st_q <= C_PICK;
        end
        C_WAIT: if (rb_done) begin
          if (rb_to) begin
            timeout_err_o <= 1'b1;
            pend_q <= '0;
          end else pend_q[PH_WAIT] <= 1'b0;
          st_q <= C_PICK;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != C_IDLE);
  assign nand_ce_no = busy_o ? ~row_q[27:24] : '1;

  nand_strobe #(
    .T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_HOLD(T_HOLD)
  ) u_strobe (
    .clk_i, .rst_ni, .go_i(go), .kind_i(go_kind), .byte_i(go_byte), .dq_i(nand_dq_i),
    .cle_o(nand_cle_o), .ale_o(nand_ale_o), .we_no(nand_we_no), .re_no(nand_re_no),
    .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe_o), .rbyte_o(strb_rbyte), .done_o(strb_done)
  );

  nand_rb_wait #(.NUM_RB(NUM_RB), .TO_W(TO_W), .T_WB(T_WB)) u_rb (
    .clk_i, .rst_ni, .start_i(rb_start), .rb_i(nand_rb_i), .sel_i(row_q[31:28]),
    .limit_i(tmo_q), .done_o(rb_done), .timeout_o(rb_to)
  );

  nand_word_buf #(.WORDS(BUF_WORDS)) u_buf (
    .clk_i, .sw_we_i(buf_we_i), .sw_waddr_i(buf_waddr_i), .sw_wdata_i(buf_wdata_i),
    .sw_raddr_i(buf_raddr_i), .sw_rdata_o(buf_rdata_o),
    .hw_we_i((st_q == C_BUS) && strb_done && is_read), .hw_waddr_i(rptr_q),
    .hw_wbyte_i(strb_rbyte), .hw_raddr_i(wptr_q), .hw_rbyte_o(hw_rbyte)
  );

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |-> !busy_o);
  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(cmd1_q) && $stable(row_q)));
  a_r11_ce_idle: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_o |-> (&nand_ce_no));
  a_r2_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni) !(nand_cle_o && nand_ale_o));
  a_r2_strobe_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> busy_o);
endmodule

// File: tb/nand_cycle_seq_test.sv
module nand_cycle_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 4, T_SETUP = 1, T_LOW = 2, T_HIGH = 1, T_HOLD = 1, T_WB = 2;
  localparam int ID_BYTES = 2, NUM_RB = 4, TO_W = 8;
  localparam int AW = $clog2(WORDS), CNT_W = $clog2(WORDS * 4) + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [14:0] code = '0;
  logic [7:0]  cmd1 = '0, cmd2 = '0, cmd3 = '0;
  logic [15:0] col = '0;
  logic [31:0] row = '0;
  logic [CNT_W-1:0] count = '0;
  logic [TO_W-1:0]  tmo = 8'd200;
  logic buf_we = 1'b0;
  logic [AW-1:0] buf_waddr = '0, buf_raddr = '0;
  logic [31:0] buf_wdata = '0, buf_rdata;
  logic busy, done, terr, cle, ale, we_n, re_n, dq_oe;
  logic [3:0] ce_n;
  logic [7:0] dq_o, dq_i = 8'h00;
  logic [NUM_RB-1:0] rb = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cycle_seq #(
    .BUF_WORDS(WORDS), .T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_HOLD(T_HOLD),
    .T_WB(T_WB), .ID_BYTES(ID_BYTES), .NUM_RB(NUM_RB), .TO_W(TO_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code),
    .cmd1_i(cmd1), .cmd2_i(cmd2), .cmd3_i(cmd3), .col_i(col), .row_i(row),
    .count_i(count), .timeout_i(tmo), .buf_we_i(buf_we), .buf_waddr_i(buf_waddr),
    .buf_wdata_i(buf_wdata), .buf_raddr_i(buf_raddr), .buf_rdata_o(buf_rdata),
    .busy_o(busy), .done_o(done), .timeout_err_o(terr), .nand_ce_no(ce_n),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_i), .nand_rb_i(rb)
  );

  int checks = 0, errors = 0, done_cnt = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rd_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // kind: 0 command, 1 address, 2 write data, 3 read data
  task automatic expect_ev(input logic [1:0] kind, input logic [7:0] b, input string tag);
    exp_q.push_back({kind, b});
    tag_q.push_back(tag);
  endtask

  task automatic match(input logic [9:0] ev);
    logic [9:0] e;
    string t;
    if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected bus cycle", 32'(ev), 32'h0);
    else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(ev == e, t, "bus cycle", 32'(ev), 32'(e));
    end
  endtask

  // monitor: flash model and scoreboard
  logic we_prev = 1'b1, re_prev = 1'b1;
  int we_w = 0, re_w = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (!we_n) we_w++;
      if (!re_n) re_w++;
      if (!we_prev && we_n) begin
        match({cle ? 2'd0 : (ale ? 2'd1 : 2'd2), dq_o});
        chk(we_w == T_LOW, "R9", "WE# low width", 32'(we_w), 32'(T_LOW));
        we_w = 0;
      end
      if (re_prev && !re_n) dq_i = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hFF;
      if (!re_prev && re_n) begin
        match({2'd3, dq_i});
        chk(re_w == T_LOW, "R9", "RE# low width", 32'(re_w), 32'(T_LOW));
        re_w = 0;
      end
      we_prev = we_n;
      re_prev = re_n;
    end
  end

  task automatic sw_write(input int w, input logic [31:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_waddr = AW'(w); buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic read_word(input int w, output logic [31:0] d);
    @(negedge clk);
    buf_raddr = AW'(w);
    #1 d = buf_rdata;
  endtask

  task automatic start_op(input logic [14:0] c);
    @(negedge clk);
    code = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R10", "done pulse seen", 32'(done), 32'h1);
    @(negedge clk);
    chk(!done && !busy, "R10", "done lasts one cycle", {done, busy}, 32'h0);
  endtask

  task automatic drain(input string tag);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, tag, "expected cycles left", 32'(exp_q.size()), 32'h0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, d0;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !terr && !cle && !ale && !dq_oe && we_n && re_n && (&ce_n),
        "R1", "reset outputs", {busy, done, terr, cle, ale, dq_oe, we_n, re_n, ce_n}, 32'h03F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && we_n && re_n && (&ce_n), "R1", "after reset", {busy, we_n, re_n, ce_n}, 32'h3F);

    // R2 R8: full program sequence, bytes from buffer MSB first
    sw_write(0, 32'h11223344);
    cmd1 = 8'h80; cmd2 = 8'h10; col = 16'h0302; row = {4'd0, 4'b0001, 24'h070605}; count = 3;
    expect_ev(0, 8'h80, "R2");
    expect_ev(1, 8'h02, "R3"); expect_ev(1, 8'h03, "R3");
    expect_ev(1, 8'h05, "R3"); expect_ev(1, 8'h06, "R3"); expect_ev(1, 8'h07, "R3");
    expect_ev(2, 8'h11, "R8"); expect_ev(2, 8'h22, "R8"); expect_ev(2, 8'h33, "R8");
    expect_ev(0, 8'h10, "R2");
    start_op(15'h7F83);
    chk(busy, "R10", "busy after start", 32'(busy), 32'h1);
    chk(ce_n == 4'b1110, "R11", "chip enables", 32'(ce_n), 32'he);
    wait_done(cyc);
    drain("R2");

    // R3: partial address runs
    cmd1 = 8'h00; col = 16'hBBAA; row = {8'h01, 24'hCCDDEE};
    expect_ev(0, 8'h00, "R3"); expect_ev(1, 8'hAA, "R3"); expect_ev(1, 8'hBB, "R3");
    start_op(15'h7000);
    wait_done(cyc);
    drain("R3");
    expect_ev(0, 8'h00, "R3"); expect_ev(1, 8'hAA, "R3"); expect_ev(1, 8'hBB, "R3");
    expect_ev(1, 8'hEE, "R3");
    start_op(15'h7800);
    wait_done(cyc);
    drain("R3");

    // R4 R5: reset code, selected line 2 held low
    cmd1 = 8'hFF; row = {4'd2, 4'b0100, 24'h0}; tmo = 8'd200;
    rb[2] = 1'b0;
    expect_ev(0, 8'hFF, "R4");
    start_op(15'h4040);
    repeat (15) @(negedge clk);
    chk(busy, "R4", "busy while line low", 32'(busy), 32'h1);
    chk(ce_n == 4'b1011, "R11", "chip enables", 32'(ce_n), 32'hb);
    rb[2] = 1'b1;
    cyc = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc >= 3 && done, "R5", "cycles from ready rise to done", 32'(cyc), 32'h3);
    @(negedge clk);
    chk(!terr, "R6", "no timeout flag", 32'(terr), 32'h0);
    drain("R4");

    // R7 R5 R12: status code, unselected line low
    cmd1 = 8'h70; row = {4'd1, 4'b0001, 24'h0}; count = 3; rb[3] = 1'b0;
    expect_ev(0, 8'h70, "R2");
    expect_ev(3, 8'hA1, "R7"); expect_ev(3, 8'hB2, "R7"); expect_ev(3, 8'hC3, "R7");
    expect_ev(3, 8'hE0, "R12");
    rd_q = '{8'hA1, 8'hB2, 8'hC3, 8'hE0};
    start_op(15'h4068);
    wait_done(cyc);
    chk(!terr, "R5", "unselected low line ignored", 32'(terr), 32'h0);
    rb[3] = 1'b1;
    drain("R7");
    read_word(0, w);
    chk(w == 32'hA1B2C3E0, "R7", "big-endian read packing", w, 32'hA1B2C3E0);

    // R12: ID read of ID_BYTES bytes overwrites only the first two lanes
    cmd1 = 8'h90; col = 16'h0000;
    expect_ev(0, 8'h90, "R2"); expect_ev(1, 8'h00, "R3");
    expect_ev(3, 8'h98, "R12"); expect_ev(3, 8'hDA, "R12");
    rd_q = '{8'h98, 8'hDA, 8'h55};
    start_op(15'h6004);
    wait_done(cyc);
    drain("R12");
    read_word(0, w);
    chk(w == 32'h98DAC3E0, "R12", "ID bytes then untouched lanes", w, 32'h98DAC3E0);
    rd_q.delete();

    // R8: zero count skips write phase
    cmd1 = 8'h80; cmd2 = 8'h10; count = 0;
    expect_ev(0, 8'h80, "R8"); expect_ev(0, 8'h10, "R8");
    start_op(15'h4180);
    wait_done(cyc);
    drain("R8");

    // R6: timeout aborts remaining phases
    cmd1 = 8'h60; cmd3 = 8'hD0; row = {4'd0, 4'b0001, 24'h0}; tmo = 8'd20; rb[0] = 1'b0;
    expect_ev(0, 8'h60, "R6");
    start_op(15'h4050);
    wait_done(cyc);
    chk(terr, "R6", "timeout flag", 32'(terr), 32'h1);
    drain("R6");
    rb[0] = 1'b1; tmo = 8'd200;
    expect_ev(0, 8'h60, "R6");
    start_op(15'h4000);
    chk(!terr, "R6", "flag cleared on start", 32'(terr), 32'h0);
    wait_done(cyc);
    drain("R6");

    // R10: start while busy ignored
    cmd1 = 8'h31; col = 16'h2211;
    expect_ev(0, 8'h31, "R10"); expect_ev(1, 8'h11, "R10"); expect_ev(1, 8'h22, "R10");
    d0 = done_cnt;
    start_op(15'h7000);
    @(negedge clk);
    cmd1 = 8'h55;
    start_op(15'h4000);
    repeat (60) @(negedge clk);
    chk(done_cnt - d0 == 1, "R10", "single done", 32'(done_cnt - d0), 32'h1);
    chk(!busy, "R10", "idle after ignored start", 32'(busy), 32'h0);
    drain("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule